// File: doc/BRIEF.md
# Reset-Key Sequencer with External DRAM Retention

This block sits in the power manager of a small SoC and turns a press of an external, active-low reset pushbutton into an orderly cold-reset sequence. The button input is synchronized to the core clock and filtered against bounce using a slow sampling tick. Once a press is accepted, the CPU core is put into cold reset. Depending on a control bit, the peripheral blocks can be reset along with it. The always-on clock unit and the GPIO unit are never touched by this block.

Before the memory controller is disturbed, the block protects the contents of external DRAM. The method depends on a memory-type control bit:

- **EDO mode.** The block takes over the strobe pins and pulls CAS# low ahead of RAS#. This makes the DRAM enter self refresh, and it stays there while the reset is held. No refresh burst is issued around this entry.
- **SDRAM mode.** The memory controller is kept out of reset. It finishes the access in flight and is then asked for exactly one CBR refresh.

A sticky cause bit records every accepted press. Software clears it by writing 1 to it through a small register port. After the button is released, the cold reset is held for a fixed number of extra clocks before the CPU is let go.

Top module: `reset_key_sequencer`

## Requirements
- R1: A press is accepted only after the input has passed a two-flop synchronizer and has been sampled low on 4 consecutive `slow_tick` pulses. A low pulse that spans fewer samples causes no reset.
- R2: On acceptance, `cpu_cold_rst` goes to 1. `periph_rst` goes to 1 together with it only when control bit 6 (peripheral keep) is 0. When that bit is 1, `periph_rst` stays 0.
- R3: Register bit 0 (key cause) is set to 1 on every accepted press. It stays 1 through the whole reset and afterwards. A register write with data bit 0 = 1 clears it; a write with data bit 0 = 0 leaves it set.
- R4: In EDO mode (control bit 7 = 0), `dram_cas_n` goes low exactly one clock before `dram_ras_n` goes low. Both stay low until the sequence ends.
- R5: In EDO mode, `mc_refresh_req` is never raised for the event, neither before nor after the self-refresh entry.
- R6: In SDRAM mode (control bit 7 = 1), `mc_rst` stays 0 throughout the event. `mc_refresh_req` rises only while `mc_busy` is 0, and exactly one request is made per event. The request is held until `mc_refresh_ack`.
- R7: In EDO mode, `mc_rst` is 1 in the same cycle as `cpu_cold_rst`, even while `mc_busy` is 1. No refresh is requested in this case.
- R8: After `key_n` returns high, `cpu_cold_rst` stays 1 for at least 8 more clocks. It falls between 8 and 14 clocks after the release.
- R9: Control bits 6 and 7 read back as written. Register bits 5 to 1 read 0. After power-on reset the register reads 0x00.
- R10: The memory-type and peripheral-keep bits are captured at acceptance. Writing them during an active sequence does not change that sequence's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-on reset, active low |
| key_n | input | 1 | Asynchronous reset pushbutton, active low |
| slow_tick | input | 1 | One-clock pulse that sets the debounce sample rate |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Write data: bit 0 write-1-to-clear cause, bit 6 peripheral keep, bit 7 SDRAM select |
| reg_rd_data | output | 8 | Register contents |
| mc_busy | input | 1 | Memory controller has an access in flight |
| mc_refresh_ack | input | 1 | Memory controller finished the requested CBR refresh |
| mc_refresh_req | output | 1 | Request one CBR refresh from the memory controller |
| mc_rst | output | 1 | Reset to the memory controller |
| cpu_cold_rst | output | 1 | Cold reset to the CPU core |
| periph_rst | output | 1 | Reset to the peripherals (not the clock or GPIO units) |
| dram_cas_n | output | 1 | EDO column strobe override, active low |
| dram_ras_n | output | 1 | EDO row strobe override, active low |

## Verification
The embedded assertions check the following on every cycle:
- the strobe order (RAS# never low without CAS#, and CAS# already low when RAS# falls);
- that the memory controller is never reset in SDRAM mode, and never asked for a refresh in EDO mode;
- that a refresh request only starts with the controller idle and ends after its acknowledge;
- that the cause bit cannot drop without a clearing write;
- that the debouncer only accepts on a low sample.

The length of the debounce window, the post-release hold count, the exactly-one refresh per event, the effect of the peripheral-keep bit, and the immunity to mode writes in mid-sequence involve whole scenarios. Only the bench's directed presses show these.

// File: rtl/rks_pkg.sv
package rks_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_EDO_CAS = 3'd1,
    SQ_DRAIN   = 3'd2,
    SQ_REFRESH = 3'd3,
    SQ_HOLD    = 3'd4,
    SQ_RELEASE = 3'd5
  } seq_state_t;

  localparam int CAUSE_BIT = 0;
  localparam int KEEP_BIT  = 6;
  localparam int SDRAM_BIT = 7;

  // saturating increment of a debounce sample count
  function automatic logic [7:0] sat_inc(input logic [7:0] cnt, input int limit);
    if (int'(cnt) >= limit) return cnt;
    return cnt + 8'd1;
  endfunction

  // true when a window counter sits on its final value
  function automatic logic window_last(input logic [7:0] cnt, input int length);
    return int'(cnt) == length - 1;
  endfunction

endpackage

// File: rtl/rks_key_filter.sv
module rks_key_filter #(
  parameter int SAMPLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_n,
  input  logic sample_tick,
  output logic key_active
);
  localparam int CW = $clog2(SAMPLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] low_cnt_q;
  logic          act_q;
  logic          key_high;
  logic [7:0]    cnt_next;

  assign key_high = sync_q[1];
  assign cnt_next = rks_pkg::sat_inc(8'(low_cnt_q), SAMPLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 2'b11;
      low_cnt_q <= '0;
      act_q     <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], key_n};
      if (key_high) begin
        low_cnt_q <= '0;
        act_q     <= 1'b0;
      end else if (sample_tick) begin
        low_cnt_q <= CW'(cnt_next);
        if (rks_pkg::window_last(8'(low_cnt_q), SAMPLES)) act_q <= 1'b1;
      end
    end
  end

  assign key_active = act_q;

  AST_ACCEPT_ON_LOW_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_active) |-> $past(!key_high && sample_tick)); // R1
  AST_DROP_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    key_high |=> !key_active); // R8

endmodule

// File: rtl/rks_ctrl_regs.sv
module rks_ctrl_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       cause_set,
  output logic [7:0] rd_data,
  output logic       sdram_sel,
  output logic       periph_keep
);
  import rks_pkg::*;

  logic cause_q, sdram_q, keep_q, clr_hit;
  logic unused_bits;

  assign clr_hit     = wr_en && wr_data[CAUSE_BIT];
  assign unused_bits = ^wr_data[5:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= 1'b0;
      sdram_q <= 1'b0;
      keep_q  <= 1'b0;
    end else begin
      if (cause_set)    cause_q <= 1'b1;
      else if (clr_hit) cause_q <= 1'b0;
      if (wr_en) begin
        sdram_q <= wr_data[SDRAM_BIT];
        keep_q  <= wr_data[KEEP_BIT];
      end
    end
  end

  always_comb begin
    rd_data            = '0;
    rd_data[CAUSE_BIT] = cause_q;
    rd_data[KEEP_BIT]  = keep_q;
    rd_data[SDRAM_BIT] = sdram_q;
  end

  assign sdram_sel   = sdram_q;
  assign periph_keep = keep_q;

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q && !clr_hit |=> cause_q); // R3
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cause_set |=> cause_q); // R3

endmodule

// File: rtl/rks_seq_fsm.sv
module rks_seq_fsm #(
  parameter int HOLD_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_active,
  input  logic sdram_sel,
  input  logic periph_keep,
  input  logic mc_busy,
  input  logic mc_refresh_ack,
  output logic cpu_cold_rst,
  output logic periph_rst,
  output logic mc_rst,
  output logic mc_refresh_req,
  output logic cause_set,
  output logic cas_phase,
  output logic ras_phase
);
  import rks_pkg::*;
  localparam int HW = (HOLD_CLKS > 1) ? $clog2(HOLD_CLKS) : 1;

  seq_state_t state_q, state_d;
  logic [HW-1:0] hold_q;
  logic sdram_mode_q, keep_mode_q;
  logic seq_active, accept_evt, edo_mode;

  assign accept_evt = (state_q == SQ_IDLE) && key_active;
  assign seq_active = (state_q != SQ_IDLE);
  assign edo_mode   = seq_active && !sdram_mode_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:    if (key_active) state_d = sdram_sel ? SQ_DRAIN : SQ_EDO_CAS;
      SQ_EDO_CAS: state_d = SQ_HOLD;
      SQ_DRAIN:   if (!mc_busy) state_d = SQ_REFRESH;
      SQ_REFRESH: if (mc_refresh_ack) state_d = SQ_HOLD;
      SQ_HOLD:    if (!key_active) state_d = SQ_RELEASE;
      SQ_RELEASE: if (window_last(8'(hold_q), HOLD_CLKS)) state_d = SQ_IDLE;
      default:    state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SQ_IDLE;
      hold_q       <= '0;
      sdram_mode_q <= 1'b0;
      keep_mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_evt) begin
        sdram_mode_q <= sdram_sel;
        keep_mode_q  <= periph_keep;
      end
      if (state_q == SQ_RELEASE) hold_q <= hold_q + HW'(1);
      else                       hold_q <= '0;
    end
  end

  assign cpu_cold_rst   = seq_active;
  assign periph_rst     = seq_active && !keep_mode_q;
  assign mc_rst         = edo_mode;
  assign mc_refresh_req = (state_q == SQ_REFRESH);
  assign cause_set      = accept_evt;
  assign cas_phase      = edo_mode;
  assign ras_phase      = edo_mode && (state_q != SQ_EDO_CAS);

  AST_SDRAM_MC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_cold_rst && sdram_mode_q |-> !mc_rst); // R6
  AST_REFRESH_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc_refresh_req) |-> $past(!mc_busy)); // R6
  AST_REFRESH_ENDS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    mc_refresh_req && mc_refresh_ack |=> !mc_refresh_req); // R6
  AST_EDO_NO_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_cold_rst && !sdram_mode_q |-> !mc_refresh_req); // R5
  AST_PERIPH_INSIDE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> cpu_cold_rst); // R2
  AST_EDO_MC_WITH_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_cold_rst) && !sdram_mode_q |-> mc_rst); // R7

endmodule

// File: rtl/rks_dram_pins.sv
module rks_dram_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic cas_phase,
  input  logic ras_phase,
  output logic cas_n,
  output logic ras_n
);
  logic cas_n_q, ras_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_n_q <= 1'b1;
      ras_n_q <= 1'b1;
    end else begin
      cas_n_q <= !cas_phase;
      ras_n_q <= !ras_phase;
    end
  end

  assign cas_n = cas_n_q;
  assign ras_n = ras_n_q;

  AST_RAS_NEEDS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n); // R4
  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n)); // R4

endmodule

// File: rtl/reset_key_sequencer.sv
module reset_key_sequencer #(
  parameter int DEB_SAMPLES = 4,
  parameter int HOLD_CLKS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_n,
  input  logic       slow_tick,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wr_data,
  output logic [7:0] reg_rd_data,
  input  logic       mc_busy,
  input  logic       mc_refresh_ack,
  output logic       mc_refresh_req,
  output logic       mc_rst,
  output logic       cpu_cold_rst,
  output logic       periph_rst,
  output logic       dram_cas_n,
  output logic       dram_ras_n
);
  logic key_active, sdram_sel, periph_keep, cause_set, cas_phase, ras_phase;

  rks_key_filter #(.SAMPLES(DEB_SAMPLES)) u_filter (
    .clk(clk), .rst_n(rst_n), .key_n(key_n), .sample_tick(slow_tick),
    .key_active(key_active));

  rks_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .cause_set(cause_set), .rd_data(reg_rd_data), .sdram_sel(sdram_sel),
    .periph_keep(periph_keep));

  rks_seq_fsm #(.HOLD_CLKS(HOLD_CLKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .key_active(key_active), .sdram_sel(sdram_sel),
    .periph_keep(periph_keep), .mc_busy(mc_busy), .mc_refresh_ack(mc_refresh_ack),
    .cpu_cold_rst(cpu_cold_rst), .periph_rst(periph_rst), .mc_rst(mc_rst),
    .mc_refresh_req(mc_refresh_req), .cause_set(cause_set),
    .cas_phase(cas_phase), .ras_phase(ras_phase));

  rks_dram_pins u_pins (
    .clk(clk), .rst_n(rst_n), .cas_phase(cas_phase), .ras_phase(ras_phase),
    .cas_n(dram_cas_n), .ras_n(dram_ras_n));

endmodule

// File: tb/reset_key_sequencer_bench.sv
`timescale 1ns/100ps
module reset_key_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_n = 1'b1;
  logic slow_tick = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic mc_busy = 1'b0;
  logic mc_refresh_ack = 1'b0;
  logic mc_refresh_req, mc_rst, cpu_cold_rst, periph_rst, dram_cas_n, dram_ras_n;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  int tick_div = 0;
  int refresh_rises = 0;
  logic req_prev = 1'b0;
  logic ack_en = 1'b0;

  always #2.5 clk = ~clk;

  reset_key_sequencer u_reset_key_sequencer (
    .clk(clk), .rst_n(rst_n), .key_n(key_n), .slow_tick(slow_tick),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .mc_busy(mc_busy), .mc_refresh_ack(mc_refresh_ack), .mc_refresh_req(mc_refresh_req),
    .mc_rst(mc_rst), .cpu_cold_rst(cpu_cold_rst), .periph_rst(periph_rst),
    .dram_cas_n(dram_cas_n), .dram_ras_n(dram_ras_n));

  // tick every 4 clocks, refresh ack model and request-edge counter
  always @(negedge clk) begin
    cycles++;
    tick_div = (tick_div + 1) % 4;
    slow_tick = (tick_div == 0);
    if (mc_refresh_req && !req_prev) refresh_rises++;
    req_prev = mc_refresh_req;
    mc_refresh_ack = ack_en && mc_refresh_req;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic wait_cpu(input logic lvl, input int limit, output int n);
    n = 0;
    while (cpu_cold_rst !== lvl && n < limit) begin @(negedge clk); n++; end
  endtask

  task automatic release_and_measure(input string req);
    int n;
    @(negedge clk); key_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (cpu_cold_rst && n < 40);
    chk(n >= 8 && n <= 14, req, n, 12);
  endtask

  task automatic t_reset;
    chk(reg_rd_data == 8'h00, "R9 reset value", reg_rd_data, 0);
    chk(!cpu_cold_rst && !periph_rst && !mc_rst && !mc_refresh_req, "R2 idle outputs",
        {cpu_cold_rst, periph_rst, mc_rst}, 0);
    chk(dram_cas_n && dram_ras_n, "R4 strobes idle high", {dram_cas_n, dram_ras_n}, 3);
  endtask

  task automatic t_regs;
    reg_write(8'hFE);
    chk(reg_rd_data == 8'hC0, "R9 readback", reg_rd_data, 8'hC0);
    reg_write(8'h00);
    chk(reg_rd_data == 8'h00, "R9 readback zero", reg_rd_data, 0);
  endtask

  task automatic t_short_press;
    int seen = 0;
    @(negedge clk); key_n = 1'b0;
    repeat (9) @(negedge clk);
    key_n = 1'b1;
    repeat (20) begin @(negedge clk); if (cpu_cold_rst) seen = 1; end
    chk(seen == 0, "R1 short press ignored", seen, 0);
    chk(reg_rd_data[0] == 1'b0, "R1 no cause on short press", reg_rd_data[0], 0);
  endtask

  task automatic t_edo;
    int n;
    int r0 = refresh_rises;
    reg_write(8'h00);
    mc_busy = 1'b1;
    @(negedge clk); key_n = 1'b0;
    wait_cpu(1'b1, 60, n);
    chk(cpu_cold_rst, "R1 long press accepted", cpu_cold_rst, 1);
    chk(n >= 10, "R1 debounce window", n, 12);
    chk(periph_rst, "R2 peripherals reset when keep=0", periph_rst, 1);
    chk(mc_rst, "R7 mc reset with cpu while busy", mc_rst, 1);
    n = 0;
    while (dram_cas_n && n < 10) begin @(negedge clk); n++; end
    chk(!dram_cas_n && dram_ras_n, "R4 CAS low first", {dram_cas_n, dram_ras_n}, 1);
    @(negedge clk);
    chk(!dram_ras_n && !dram_cas_n, "R4 RAS one clock later", {dram_cas_n, dram_ras_n}, 0);
    repeat (30) @(negedge clk);
    chk(!dram_ras_n && !dram_cas_n, "R4 strobes held low", {dram_cas_n, dram_ras_n}, 0);
    chk(reg_rd_data[0], "R3 cause set", reg_rd_data[0], 1);
    release_and_measure("R8 hold after release");
    repeat (3) @(negedge clk);
    chk(dram_cas_n && dram_ras_n, "R4 strobes released", {dram_cas_n, dram_ras_n}, 3);
    chk(refresh_rises == r0, "R5 no refresh in EDO mode", refresh_rises - r0, 0);
    chk(reg_rd_data[0], "R3 cause survives reset", reg_rd_data[0], 1);
    mc_busy = 1'b0;
  endtask

  task automatic t_clear;
    reg_write(8'h00);
    chk(reg_rd_data[0], "R3 write 0 keeps cause", reg_rd_data[0], 1);
    reg_write(8'h01);
    chk(!reg_rd_data[0], "R3 write 1 clears cause", reg_rd_data[0], 0);
  endtask

  task automatic t_sdram;
    int n;
    int r0 = refresh_rises;
    int mc_seen = 0;
    int strobe_seen = 0;
    int busy_req = 0;
    reg_write(8'hC0);
    mc_busy = 1'b1;
    ack_en = 1'b1;
    @(negedge clk); key_n = 1'b0;
    wait_cpu(1'b1, 60, n);
    chk(cpu_cold_rst, "R2 sdram press accepted", cpu_cold_rst, 1);
    chk(!periph_rst, "R2 peripherals kept when keep=1", periph_rst, 0);
    reg_write(8'h00);
    repeat (10) begin
      @(negedge clk);
      if (mc_refresh_req) busy_req = 1;
      if (mc_rst) mc_seen = 1;
    end
    chk(busy_req == 0, "R6 no refresh while busy", busy_req, 0);
    mc_busy = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (mc_rst) mc_seen = 1;
      if (!dram_cas_n || !dram_ras_n) strobe_seen = 1;
      if (periph_rst) mc_seen = 2;
    end
    chk(mc_seen == 0, "R6 R10 mc and peripherals untouched", mc_seen, 0);
    chk(strobe_seen == 0, "R10 no EDO strobes after mode write", strobe_seen, 0);
    chk(refresh_rises - r0 == 1, "R6 exactly one refresh", refresh_rises - r0, 1);
    release_and_measure("R8 sdram hold after release");
    chk(refresh_rises - r0 == 1, "R6 single refresh per event", refresh_rises - r0, 1);
    ack_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_short_press();
    t_edo();
    t_clear();
    t_sdram();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule